// File: doc/BRIEF.md
# Boundary Scan Register Chain

A chain of two-stage boundary cells that sits between a device's pins and its core logic. Input cells stand in the path from the pins to the core. Each output pin has two cells: a data cell and a control cell, which sit in the path from the core to the pin and to its output enable. A TAP controller outside the block supplies the test clock and the capture, shift and update enables. The instruction decoder supplies a two-bit mode.

Each cell has two stages. The first stage captures a parallel value or shifts serial data from `tdi_i` toward `tdo_o`. The second stage is a hold stage, and it changes only on an update. Only the hold stage can reach the core or the pins, and only through the mode multiplexers. Shifting therefore never disturbs the functional paths. Supported uses are normal operation, sampling, preloading, driving the board from the chain, and driving the core from the chain.

Top module: `bsr_chain`

## Requirements
- R1: While `rst_ni` is low, every first stage and every hold stage is cleared at once, and the outputs follow the functional paths whatever `mode_i` is. After release, the chain reads back zero and the test-driven outputs show zero.
- R2: Mode encoding is 0 = functional and 1 = sample/preload. In both modes `core_in_o` equals `pin_in_i`, `pin_out_o` equals `core_out_i` and `pin_oe_o` equals `core_oe_i`. Hold contents have no effect on any output.
- R3: Chain position 0 is nearest `tdi_i`. Positions 0..N_IN-1 are input cells, and input cell i captures `pin_in_i[i]`. For output k, position N_IN+2k is the data cell, which captures `core_out_i[k]`, and position N_IN+2k+1 is the control cell, which captures `core_oe_i[k]`. Capture happens on a rising `tck_i` edge while `capture_i` is high.
- R4: On each rising edge with `shift_i` high, every first stage takes the value of its neighbour nearer `tdi_i`, and position 0 takes `tdi_i`. `tdo_o` always shows the first stage at the last position.
- R5: When `capture_i` and `shift_i` are both high at a rising edge, the capture takes effect and the shift does not.
- R6: A hold stage copies its first stage on a falling `tck_i` edge while `update_i` is high. At every other time it keeps its value, so shifting with no update leaves the test-driven outputs unchanged.
- R7: Mode 2 is external test. `pin_out_o[k]` comes from the hold stage of data cell k and `pin_oe_o[k]` from the hold stage of control cell k, while `core_in_o` still follows `pin_in_i`.
- R8: Mode 3 is internal test. `core_in_o` comes from the hold stages of the input cells, and the pins and enables are driven from the output-side hold stages as in mode 2.
- R9: When `shift_i` and `update_i` are high in the same cycle, the hold stages take the contents the first stages had before that cycle's shift edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous test reset, active low |
| capture_i | input | 1 | Capture enable from the TAP controller |
| shift_i | input | 1 | Shift enable from the TAP controller |
| update_i | input | 1 | Update enable, acted on at the falling edge |
| mode_i | input | 2 | Mode from the instruction decoder |
| tdi_i | input | 1 | Serial scan input |
| tdo_o | output | 1 | Serial scan output |
| pin_in_i | input | N_IN | Values arriving at the input pins |
| core_in_o | output | N_IN | Values presented to the core inputs |
| core_out_i | input | N_OUT | Output values from the core |
| core_oe_i | input | N_OUT | Output enables from the core |
| pin_out_o | output | N_OUT | Values driven to the output pins |
| pin_oe_o | output | N_OUT | Enables driven to the output pins |

## Verification
Capture and shift can be requested in the same rising edge. The bench raises both enables for one cycle, with the first stages prefilled with zeros and the inputs held at a distinct pattern. It then shifts the chain out and requires the parallel snapshot, not the shifted zeros. Shift and update can also share a cycle. The bench holds both enables high for one cycle in external-test mode and requires the pins to show the chain contents from before that shift.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  typedef enum logic [1:0] {
    BSR_FUNC   = 2'd0,
    BSR_SAMPLE = 2'd1,
    BSR_EXTEST = 2'd2,
    BSR_INTEST = 2'd3
  } bsr_mode_e;

  function automatic logic drives_pins(bsr_mode_e m);
    return (m == BSR_EXTEST) || (m == BSR_INTEST);
  endfunction
endpackage

// File: rtl/bsr_cell.sv
module bsr_cell (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic capture_i,
  input  logic shift_i,
  input  logic update_i,
  input  logic par_i,
  input  logic scan_i,
  output logic cap_o,
  output logic hold_o
);
  // capture wins over shift
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)        cap_o <= 1'b0;
    else if (capture_i) cap_o <= par_i;
    else if (shift_i)   cap_o <= scan_i;
  end

  // hold stage loads on the falling edge only
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni)       hold_o <= 1'b0;
    else if (update_i) hold_o <= cap_o;
  end
endmodule

// File: rtl/bsr_pin_mux.sv
module bsr_pin_mux
  import bsr_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int N_OUT = 2
) (
  input  bsr_mode_e        mode_i,
  input  logic [N_IN-1:0]  pin_in_i,
  input  logic [N_IN-1:0]  in_hold_i,
  input  logic [N_OUT-1:0] core_out_i,
  input  logic [N_OUT-1:0] core_oe_i,
  input  logic [N_OUT-1:0] out_hold_i,
  input  logic [N_OUT-1:0] ctl_hold_i,
  output logic [N_IN-1:0]  core_in_o,
  output logic [N_OUT-1:0] pin_out_o,
  output logic [N_OUT-1:0] pin_oe_o
);
  logic drive_core, drive_pins;

  always_comb begin
    drive_core = (mode_i == BSR_INTEST);
    drive_pins = drives_pins(mode_i);
    core_in_o  = drive_core ? in_hold_i  : pin_in_i;
    pin_out_o  = drive_pins ? out_hold_i : core_out_i;
    pin_oe_o   = drive_pins ? ctl_hold_i : core_oe_i;
  end
endmodule

// File: rtl/bsr_chain.sv
module bsr_chain
  import bsr_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int N_OUT = 2
) (
  input  logic             tck_i,
  input  logic             rst_ni,
  input  logic             capture_i,
  input  logic             shift_i,
  input  logic             update_i,
  input  logic [1:0]       mode_i,
  input  logic             tdi_i,
  output logic             tdo_o,
  input  logic [N_IN-1:0]  pin_in_i,
  output logic [N_IN-1:0]  core_in_o,
  input  logic [N_OUT-1:0] core_out_i,
  input  logic [N_OUT-1:0] core_oe_i,
  output logic [N_OUT-1:0] pin_out_o,
  output logic [N_OUT-1:0] pin_oe_o
);
  localparam int LEN = N_IN + 2 * N_OUT;

  logic [LEN-1:0]   par_d, scan_d, cap_q, hold_q;
  logic [N_OUT-1:0] out_hold, ctl_hold;
  bsr_mode_e        mode_eff;

  // test reset forces functional paths
  assign mode_eff = rst_ni ? bsr_mode_e'(mode_i) : BSR_FUNC;

  assign par_d[N_IN-1:0] = pin_in_i;
  for (genvar k = 0; k < N_OUT; k++) begin : g_out_map
    assign par_d[N_IN+2*k]   = core_out_i[k];
    assign par_d[N_IN+2*k+1] = core_oe_i[k];
    assign out_hold[k]       = hold_q[N_IN+2*k];
    assign ctl_hold[k]       = hold_q[N_IN+2*k+1];
  end

  assign scan_d = {cap_q[LEN-2:0], tdi_i};
  assign tdo_o  = cap_q[LEN-1];

  for (genvar i = 0; i < LEN; i++) begin : g_cell
    bsr_cell u_cell (
      .tck_i    (tck_i),
      .rst_ni   (rst_ni),
      .capture_i(capture_i),
      .shift_i  (shift_i),
      .update_i (update_i),
      .par_i    (par_d[i]),
      .scan_i   (scan_d[i]),
      .cap_o    (cap_q[i]),
      .hold_o   (hold_q[i])
    );
  end

  bsr_pin_mux #(.N_IN(N_IN), .N_OUT(N_OUT)) u_mux (
    .mode_i    (mode_eff),
    .pin_in_i  (pin_in_i),
    .in_hold_i (hold_q[N_IN-1:0]),
    .core_out_i(core_out_i),
    .core_oe_i (core_oe_i),
    .out_hold_i(out_hold),
    .ctl_hold_i(ctl_hold),
    .core_in_o (core_in_o),
    .pin_out_o (pin_out_o),
    .pin_oe_o  (pin_oe_o)
  );
endmodule

// File: rtl/bsr_chain_chk.sv
module bsr_chain_chk #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 2,
  localparam int LEN  = N_IN + 2 * N_OUT
) (
  input logic             tck_i,
  input logic             rst_ni,
  input logic             capture_i,
  input logic             shift_i,
  input logic             update_i,
  input logic [1:0]       mode_i,
  input logic             tdi_i,
  input logic             tdo_o,
  input logic [N_IN-1:0]  pin_in_i,
  input logic [N_IN-1:0]  core_in_o,
  input logic [N_OUT-1:0] core_out_i,
  input logic [N_OUT-1:0] core_oe_i,
  input logic [N_OUT-1:0] pin_out_o,
  input logic [N_OUT-1:0] pin_oe_o,
  input logic [LEN-1:0]   cap_q,
  input logic [LEN-1:0]   hold_q
);
  // R1: reset forces the functional paths
  always_comb begin
    if (!rst_ni) begin
      a_r1_func_in_reset: assert (core_in_o == pin_in_i && pin_out_o == core_out_i
                                  && pin_oe_o == core_oe_i);
    end
  end

  // R1: holds come out of reset cleared
  a_r1_hold_cleared: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !$past(rst_ni) |-> hold_q == '0);

  // R4: first cell takes tdi
  a_r4_shift_entry: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (shift_i && !capture_i) |=> cap_q[0] == $past(tdi_i));

  if (LEN > 1) begin : g_tdo
    // R4: tdo shows the neighbour after a shift
    a_r4_shift_exit: assert property (@(posedge tck_i) disable iff (!rst_ni)
      (shift_i && !capture_i) |=> tdo_o == $past(cap_q[LEN-2]));
  end

  // R5: capture beats shift
  a_r5_capture_wins: assert property (@(posedge tck_i) disable iff (!rst_ni)
    capture_i |=> cap_q[0] == $past(pin_in_i[0]));

  // R6: update copies, otherwise hold is stable
  a_r6_update_copy: assert property (@(negedge tck_i) disable iff (!rst_ni)
    update_i |=> hold_q == $past(cap_q));
  a_r6_hold_stable: assert property (@(negedge tck_i) disable iff (!rst_ni)
    !update_i |=> $stable(hold_q));

  // R7: pins stay put in external test without update
  a_r7_ext_pins_stable: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (mode_i == 2'd2 && $past(mode_i) == 2'd2 && $past(rst_ni) && !update_i)
    |-> ($stable(pin_out_o) && $stable(pin_oe_o)));
endmodule

bind bsr_chain bsr_chain_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
  .tck_i     (tck_i),
  .rst_ni    (rst_ni),
  .capture_i (capture_i),
  .shift_i   (shift_i),
  .update_i  (update_i),
  .mode_i    (mode_i),
  .tdi_i     (tdi_i),
  .tdo_o     (tdo_o),
  .pin_in_i  (pin_in_i),
  .core_in_o (core_in_o),
  .core_out_i(core_out_i),
  .core_oe_i (core_oe_i),
  .pin_out_o (pin_out_o),
  .pin_oe_o  (pin_oe_o),
  .cap_q     (cap_q),
  .hold_q    (hold_q)
);

// File: tb/sim_bsr_chain.sv
`timescale 1ns/1ps
module sim_bsr_chain;
  localparam int N_IN  = 4;
  localparam int N_OUT = 2;
  localparam int LEN   = N_IN + 2 * N_OUT;

  // {mode, pin_in, core_out, core_oe, preload, exp core_in, exp pin_out, exp pin_oe, exp capture}
  localparam logic [33:0] VEC [4] = '{
    {2'd0, 4'b1010, 2'b01, 2'b10, 8'hF5, 4'b1010, 2'b01, 2'b10, 8'h9A},
    {2'd1, 4'b0110, 2'b10, 2'b11, 8'h3C, 4'b0110, 2'b10, 2'b11, 8'hE6},
    {2'd2, 4'b1100, 2'b11, 2'b00, 8'h63, 4'b1100, 2'b10, 2'b01, 8'h5C},
    {2'd3, 4'b0011, 2'b00, 2'b01, 8'h99, 4'b1001, 2'b01, 2'b10, 8'h23}
  };

  logic tck = 1'b0, rst_n = 1'b0;
  logic capture = 1'b0, shift = 1'b0, update = 1'b0, tdi = 1'b0;
  logic [1:0] mode = 2'd2;
  logic [N_IN-1:0]  pin_in = '0, core_in;
  logic [N_OUT-1:0] core_out = '0, core_oe = '0, pin_out, pin_oe;
  logic tdo;
  int checks = 0, errors = 0;
  logic [LEN-1:0] rd;

  always #2.5 tck = ~tck;

  bsr_chain #(.N_IN(N_IN), .N_OUT(N_OUT)) u0 (
    .tck_i(tck), .rst_ni(rst_n), .capture_i(capture), .shift_i(shift),
    .update_i(update), .mode_i(mode), .tdi_i(tdi), .tdo_o(tdo),
    .pin_in_i(pin_in), .core_in_o(core_in), .core_out_i(core_out),
    .core_oe_i(core_oe), .pin_out_o(pin_out), .pin_oe_o(pin_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge tck);
    #1;
  endtask

  task automatic shift_vec(input logic [LEN-1:0] din, output logic [LEN-1:0] dout);
    for (int k = 0; k < LEN; k++) begin
      tdi = din[LEN-1-k];
      shift = 1'b1;
      dout[LEN-1-k] = tdo;
      cyc();
    end
    shift = 1'b0;
  endtask

  task automatic pulse_update();
    update = 1'b1;
    cyc();
    update = 1'b0;
  endtask

  task automatic pulse_capture();
    capture = 1'b1;
    cyc();
    capture = 1'b0;
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset forces functional paths even in external-test mode
    pin_in = 4'b0101; core_out = 2'b11; core_oe = 2'b11;
    cyc(); cyc();
    check("R1 core_in in reset", 8'(core_in), 8'h05);
    check("R1 pin_out in reset", 8'(pin_out), 8'h03);
    check("R1 pin_oe in reset", 8'(pin_oe), 8'h03);
    rst_n = 1'b1;
    cyc();
    check("R1 pin_out holds cleared", 8'(pin_out), 8'h00);
    check("R1 pin_oe holds cleared", 8'(pin_oe), 8'h00);
    shift_vec('0, rd);
    check("R1 chain cleared", rd, 8'h00);

    // table: R2 R3 R7 R8
    for (int v = 0; v < 4; v++) begin
      mode = VEC[v][33:32]; pin_in = VEC[v][31:28];
      core_out = VEC[v][27:26]; core_oe = VEC[v][25:24];
      shift_vec(VEC[v][23:16], rd);
      pulse_update();
      check("R2/R7/R8 core_in", 8'(core_in), 8'(VEC[v][15:12]));
      check("R2/R7/R8 pin_out", 8'(pin_out), 8'(VEC[v][11:10]));
      check("R2/R7/R8 pin_oe", 8'(pin_oe), 8'(VEC[v][9:8]));
      pulse_capture();
      shift_vec('0, rd);
      check("R3 capture", rd, VEC[v][7:0]);
    end

    // R4: ordering through the chain
    mode = 2'd2;
    shift_vec(8'h2D, rd);
    shift_vec(8'h00, rd);
    check("R4 shift order", rd, 8'h2D);

    // R6: shifting without update leaves pins alone
    shift_vec(8'hFF, rd);
    pulse_update();
    check("R6 pin_out after update", 8'(pin_out), 8'h03);
    check("R6 pin_oe after update", 8'(pin_oe), 8'h03);
    shift_vec(8'h00, rd);
    check("R6 pin_out during shift", 8'(pin_out), 8'h03);
    check("R6 pin_oe during shift", 8'(pin_oe), 8'h03);

    // R5: capture and shift in the same edge
    mode = 2'd1; pin_in = 4'b1111; core_out = 2'b00; core_oe = 2'b00;
    tdi = 1'b0; capture = 1'b1; shift = 1'b1;
    cyc();
    capture = 1'b0; shift = 1'b0;
    shift_vec('0, rd);
    check("R5 capture priority", rd, 8'h0F);

    // R9: shift and update in the same cycle
    mode = 2'd2;
    shift_vec(8'h50, rd);
    tdi = 1'b1; shift = 1'b1; update = 1'b1;
    cyc();
    shift = 1'b0; update = 1'b0;
    check("R9 pin_out pre-shift value", 8'(pin_out), 8'h03);
    check("R9 pin_oe pre-shift value", 8'(pin_oe), 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule